// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a single-clock synchronous static memory with one shared bidirectional data bus. On every rising edge it takes in the address, the three chip-select lines, the write controls and the bus contents. When the chip is selected, each cycle is either a write or a read. A write stores any subset of the 9-bit byte lanes, or all of them through the global-write line. A read returns the word through an output register, so the data arrives one cycle after the read was taken in.

Bus drive follows a two-stage pipeline. Once a read is registered, the read data is driven for the following cycle. After a deselect or a write is registered, the bus is still driven for one more cycle and is released after that. The output enable overrides the pipeline and releases the bus at once. Address sequencing, such as bursts, is done outside this block, which takes a plain address on each cycle. The word is either four lanes (36 bits) or two lanes (18 bits), chosen by a parameter.

Top module: `pipe_sram`

## Requirements
- R1: Address, chip selects, write controls and bus data are sampled only on the rising edge of `clk`. A read taken in on edge N drives its word on `dq` from just after edge N+1 until edge N+2.
- R2: The chip is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0 on the same edge. An unselected edge neither writes nor reads.
- R3: Byte lane k occupies bits [9k+8:9k]. On a selected edge with `wr_all_n`=1, lane k is written when `lane_en_n`=0 and `lane_wr_n[k]`=0. Every other lane keeps its stored value. When `lane_en_n`=1, the `lane_wr_n` inputs have no effect.
- R4: On a selected edge with `wr_all_n`=0, all lanes are written, whatever the values of `lane_en_n` and `lane_wr_n`.
- R5: A selected edge at which no lane is written is a read of `addr`.
- R6: After a read, if a deselect or a write is registered on the next edge, the bus stays driven with the read data for one more cycle and goes high-impedance after the edge that follows.
- R7: While `oe_n`=1 the block does not drive `dq`. This holds in every pipeline state.
- R8: A read of an address on the edge directly after a write to that address returns the newly written data.
- R9: While `rst_n`=0, and after reset until the first read, `dq` is not driven.
- R10: Parameter `LANES` selects 4 lanes (36-bit word) or 2 lanes (18-bit word). The lane layout of R3 applies in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline state |
| addr | input | ADDR_W | Word address |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write, active low; writes all lanes |
| lane_en_n | input | 1 | Lane write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | 9*LANES | Shared data bus |

## Verification
The bench builds the block with `LANES`=4 and `ADDR_W`=4. The four-lane word allows every lane subset to be tested, including patterns where alternate lanes are written. The 16-word array is small enough that a behavioural model can track every location the bench writes. With these values, the bench can run back-to-back read streams, reads that end in a deselect or a write, and the case where a write is followed at once by a read of the same address. It also pulses `oe_n` in the middle of a read stream to check that the bus is released at once.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } sram_cmd_e;

  function automatic logic chip_selected(input logic s0_n, input logic s1, input logic s2_n);
    return !s0_n && s1 && !s2_n;
  endfunction
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              wr_all_n,
  input  logic              lane_en_n,
  input  logic [LANES-1:0]  lane_wr_n,
  output logic              sel,
  output logic [LANES-1:0]  lane_mask,
  output sram_cmd_e         cmd,
  output logic              rd_q,
  output logic [ADDR_W-1:0] rd_addr_q
);
  always_comb begin
    sel = chip_selected(cs0_n, cs1, cs2_n);
    if (!sel)           lane_mask = '0;
    else if (!wr_all_n) lane_mask = '1;
    else if (!lane_en_n) lane_mask = ~lane_wr_n;
    else                lane_mask = '0;
    if (!sel)                cmd = CMD_IDLE;
    else if (|lane_mask)     cmd = CMD_WRITE;
    else                     cmd = CMD_READ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_q      <= (cmd == CMD_READ);
      rd_addr_q <= addr;
    end
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        lane_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd_q,
  input  logic [ADDR_W-1:0]       rd_addr_q,
  output logic [LANES*LANE_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_mask[l]) mem[wr_addr] <= wdata[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)    q[l*LANE_W +: LANE_W] <= '0;
      else if (rd_q) q[l*LANE_W +: LANE_W] <= mem[rd_addr_q];
    end
  end
endmodule

// File: rtl/sram_out_pipe.sv
module sram_out_pipe (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_q,
  input  logic oe_n,
  output logic drv_pipe,
  output logic drv_on
);
  always_ff @(posedge clk) begin
    if (!rst_n) drv_pipe <= 1'b0;
    else        drv_pipe <= rd_q;
  end

  assign drv_on = drv_pipe && !oe_n;
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              wr_all_n,
  input  logic              lane_en_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              oe_n,
  inout  wire  [WORD_W-1:0] dq
);
  logic              sel;
  logic [LANES-1:0]  lane_mask;
  sram_cmd_e         cmd;
  logic              rd_cyc;
  logic              wr_cyc;
  logic              rd_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [WORD_W-1:0] q;
  logic              drv_pipe;
  logic              drv_on;

  assign rd_cyc = (cmd == CMD_READ);
  assign wr_cyc = (cmd == CMD_WRITE);

  sram_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .wr_all_n(wr_all_n), .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n),
    .sel(sel), .lane_mask(lane_mask), .cmd(cmd), .rd_q(rd_q), .rd_addr_q(rd_addr_q)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_arr (
    .clk(clk), .rst_n(rst_n), .lane_mask(lane_mask), .wr_addr(addr), .wdata(dq),
    .rd_q(rd_q), .rd_addr_q(rd_addr_q), .q(q)
  );

  sram_out_pipe u_out (
    .clk(clk), .rst_n(rst_n), .rd_q(rd_q), .oe_n(oe_n),
    .drv_pipe(drv_pipe), .drv_on(drv_on)
  );

  assign dq = drv_on ? q : {WORD_W{1'bz}};
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_n,
  input logic             sel,
  input logic             wr_all_n,
  input logic             rd_cyc,
  input logic             wr_cyc,
  input logic [LANES-1:0] lane_mask,
  input logic             drv_pipe,
  input logic             drv_on
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assert_oe_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drv_on);

  assert_drive_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (drv_pipe == $past(rd_cyc, 2)));

  assert_global_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr_all_n) |-> (&lane_mask));

  assert_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (lane_mask == '0 && !rd_cyc && !wr_cyc));

  assert_read_or_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> $countones({rd_cyc, wr_cyc}) == 1);

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> !drv_pipe);
endmodule

bind pipe_sram pipe_sram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .sel(sel), .wr_all_n(wr_all_n),
  .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .lane_mask(lane_mask),
  .drv_pipe(drv_pipe), .drv_on(drv_on)
);

// File: tb/pipe_sram_tb.sv
module pipe_sram_tb;
  localparam int AW = 4;
  localparam int NL = 4;
  localparam int W  = NL * 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
  logic          wr_all_n = 1'b1, lane_en_n = 1'b1;
  logic [NL-1:0] lane_wr_n = '1;
  logic          oe_n = 1'b1;
  logic          tb_den = 1'b0;
  logic [W-1:0]  tb_data = '0;
  wire  [W-1:0]  dq;

  assign dq = tb_den ? tb_data : {W{1'bz}};

  pipe_sram #(.ADDR_W(AW), .LANES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .wr_all_n(wr_all_n), .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n),
    .oe_n(oe_n), .dq(dq)
  );

  // Behavioural reference: word store plus two pipeline flags
  logic [W-1:0] ref_mem [int];
  bit           ref_rd1, ref_drv;
  int           ref_rda;
  logic [W-1:0] ref_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_rd1 = 0; ref_drv = 0; ref_q = '0;
    end else begin
      bit on;
      bit [NL-1:0] m;
      on = (cs0_n == 0) && (cs1 == 1) && (cs2_n == 0);
      m = '0;
      if (on && !wr_all_n) m = '1;
      else if (on && !lane_en_n) m = ~lane_wr_n;
      ref_drv = ref_rd1;
      if (ref_rd1) ref_q = ref_mem.exists(ref_rda) ? ref_mem[ref_rda] : 'x;
      if (m != 0) begin
        logic [W-1:0] w;
        w = ref_mem.exists(int'(addr)) ? ref_mem[int'(addr)] : 'x;
        for (int k = 0; k < NL; k++)
          if (m[k]) w[k*9 +: 9] = dq[k*9 +: 9];
        ref_mem[int'(addr)] = w;
      end
      ref_rd1 = on && (m == 0);
      ref_rda = int'(addr);
    end
  end

  int n_cmp = 0, n_bad = 0;
  string tag = "R9";
  bit done = 0;

  task automatic compare();
    logic [W-1:0] exp;
    exp = (ref_drv && !oe_n) ? ref_q : (tb_den ? tb_data : {W{1'bz}});
    n_cmp++;
    if (dq !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t dq=%h expected=%h", tag, $time, dq, exp);
    end
  endtask

  // apply inputs at a falling edge, compare at the next falling edge
  task automatic tick(input bit s0n, input bit s1, input bit s2n, input int a,
                      input bit gw_n, input bit en_n, input bit [NL-1:0] lw_n,
                      input bit oen, input bit drive, input logic [W-1:0] d);
    cs0_n = s0n; cs1 = s1; cs2_n = s2n; addr = AW'(a);
    wr_all_n = gw_n; lane_en_n = en_n; lane_wr_n = lw_n;
    oe_n = oen; tb_den = drive; tb_data = d;
    @(negedge clk);
    compare();
  endtask

  task automatic wr_global(input int a, input logic [W-1:0] d);
    tick(0, 1, 0, a, 0, 1, '1, 1, 1, d);
  endtask
  task automatic wr_lanes(input int a, input bit en_n, input bit [NL-1:0] lw_n, input logic [W-1:0] d);
    tick(0, 1, 0, a, 1, en_n, lw_n, 1, 1, d);
  endtask
  task automatic rd(input int a, input bit oen);
    tick(0, 1, 0, a, 1, 1, '1, oen, 0, '0);
  endtask
  task automatic idle(input bit oen);
    tick(1, 0, 1, 0, 1, 1, '1, oen, 0, '0);
  endtask

  function automatic logic [W-1:0] pat(input int a);
    return {W{1'b0}} | (W'(64'h9A5C3E1F0) ^ (W'(a) * W'(36'h1_0842_1085)));
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); compare();
    @(negedge clk); compare();
    rst_n = 1'b1;
    tag = "R9"; idle(0); idle(0);

    tag = "R4"; // global write whatever the lane controls say
    for (int a = 0; a < 8; a++) wr_global(a, pat(a));
    idle(1);
    tag = "R1 R5";
    for (int a = 0; a < 8; a++) rd(a, 0);
    idle(0); idle(0);

    tag = "R3 R10"; // lanes 0 and 2 written, 1 and 3 kept
    wr_lanes(3, 0, 4'b1010, {W{1'b1}});
    tag = "R3"; // lane selects ignored without the qualifier
    wr_lanes(4, 1, 4'b0000, '0);
    idle(1);
    rd(3, 0); rd(4, 0); idle(0); idle(0);

    tag = "R4";
    tick(0, 1, 0, 5, 0, 0, 4'b1110, 1, 1, 36'h123456789);
    idle(1); rd(5, 0); idle(0); idle(0);

    tag = "R2"; // each select inactive in turn
    tick(1, 1, 0, 6, 0, 1, '1, 1, 1, '0);
    tick(0, 0, 0, 6, 0, 1, '1, 1, 1, '0);
    tick(0, 1, 1, 6, 0, 1, '1, 1, 1, '0);
    idle(1); rd(6, 0); idle(0); idle(0);

    tag = "R6"; // read then deselect; read then write
    rd(1, 0); idle(0); idle(0); idle(0);
    rd(2, 0); wr_lanes(9, 0, 4'b0111, 36'hFEDCBA987);
    idle(1); idle(0);

    tag = "R7";
    rd(0, 0); rd(1, 0); rd(2, 1); rd(3, 0); idle(1); idle(0);

    tag = "R8";
    for (int a = 10; a < 14; a++) begin
      wr_global(a, ~pat(a));
      rd(a, 0);
      idle(0);
    end
    idle(0); idle(0);

    tag = "R9"; rst_n = 1'b0; rd(0, 0); rd(1, 0);
    rst_n = 1'b1; idle(0); idle(0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule